// File: doc/BRIEF.md
# Nibble RAM Exchange and Pointer Unit

This block is one slice of a small 4-bit processor core. It owns the accumulator, a 2-bit row pointer, a 4-bit column pointer and a 64-entry nibble RAM. The RAM address is the row pointer followed by the column pointer. Each cycle the unit decodes one 9-bit instruction word.

There are three exchange instructions. Each swaps the accumulator with the addressed nibble and flips bits of the row pointer with a 2-bit immediate. Two of them also step the column pointer up or down with wrap-around. When the step wraps, they raise a one-cycle skip request so that the sequencer discards the following instruction. One further code produces a one-cycle pulse that clears the watchdog flag.

The rest of the core can load the accumulator through a write port. All other instruction codes leave the slice untouched.

Top module: `xch_unit`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the row pointer and the column pointer to zero. It also holds the skip and watchdog-clear outputs low.
- R2: Code 0x060+j (binary 0_0110_00jj) swaps the accumulator with RAM[row*16+col], using the pointer values from before the instruction. It leaves the column pointer unchanged and raises no skip.
- R3: Each exchange code (0x060+j, 0x068+j, 0x06C+j) replaces the row pointer with its value XOR j, where j is instruction bits [1:0].
- R4: Code 0x068+j does the swap and then adds 1 to the column pointer, so 15 wraps to 0. The skip output is high in the following cycle exactly when the new column value is 0.
- R5: Code 0x06C+j does the swap and then subtracts 1 from the column pointer, so 0 wraps to 15. The skip output is high in the following cycle exactly when the new column value is 15.
- R6: Skip is a registered output. It is high in a cycle only if the previous cycle held an increment or decrement code whose wrap condition was met.
- R7: Code 0x00F drives the watchdog-clear output high for exactly the next cycle. It changes neither pointer, nor the RAM, nor the skip output.
- R8: Any other code changes neither pointer nor the RAM, and raises neither output pulse. This includes 0x064..0x067 and any code with bit 8 set. The accumulator is also unchanged unless the load port is used.
- R9: When the instruction is not an exchange code, acc_wr_en loads acc_wr_data into the accumulator. During an exchange code the load port is ignored and the swap wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 9 | Decoded instruction word for this cycle |
| acc_wr_en | input | 1 | Accumulator load request from the rest of the core |
| acc_wr_data | input | 4 | Accumulator load value |
| acc_o | output | 4 | Accumulator contents |
| row_o | output | 2 | Row pointer |
| col_o | output | 4 | Column pointer |
| skip_o | output | 1 | Request to discard the next instruction |
| wdt_clr_o | output | 1 | One-cycle watchdog-flag clear pulse |

## Verification
The accumulator and both pointers are visible on the ports one cycle after each instruction. A wrong pointer update or a wrong skip therefore shows up at the very next sample. A corrupted RAM nibble stays hidden until a later exchange reaches that address and returns it into the accumulator. For that reason the bench first fills every cell with a known value. It then runs long mixed instruction streams, so that every write is read back within a few hundred cycles.

// File: rtl/xch_pkg.sv
`timescale 1ns/1ps
package xch_pkg;

    localparam int INSTR_W = 9;
    localparam int IMM_W   = 2;

    localparam logic [INSTR_W-1:0] CODE_WDT = 9'h00F;
    localparam logic [4:0]         GRP_XCH  = 5'b00110;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_XCH,
        OP_XCH_INC,
        OP_XCH_DEC,
        OP_WDT
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [IMM_W-1:0] imm;
    } dec_t;

    function automatic dec_t decode(input logic [INSTR_W-1:0] ins);
        dec_t d;
        d.op  = OP_NONE;
        d.imm = ins[IMM_W-1:0];
        if (ins[8:4] == GRP_XCH) begin
            case (ins[3:2])
                2'b00:   d.op = OP_XCH;
                2'b10:   d.op = OP_XCH_INC;
                2'b11:   d.op = OP_XCH_DEC;
                default: d.op = OP_NONE;
            endcase
        end else if (ins == CODE_WDT) begin
            d.op = OP_WDT;
        end
        return d;
    endfunction

    function automatic logic is_exchange(input op_e op);
        return (op == OP_XCH) || (op == OP_XCH_INC) || (op == OP_XCH_DEC);
    endfunction

endpackage

// File: rtl/xch_decoder.sv
`timescale 1ns/1ps
module xch_decoder
    import xch_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec_o,
    output logic               xch_o
);
    always_comb begin
        dec_o = decode(instr);
        xch_o = is_exchange(dec_o.op);
    end
endmodule

// File: rtl/xch_pointer.sv
`timescale 1ns/1ps
module xch_pointer
    import xch_pkg::*;
#(
    parameter int ROW_W = 2,
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  dec_t             dec_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic             skip_o
);
    localparam logic [COL_W-1:0] COL_MAX = {COL_W{1'b1}};
    localparam logic [COL_W-1:0] COL_ONE = COL_W'(1);

    logic [ROW_W-1:0] row_q, row_d;
    logic [COL_W-1:0] col_q, col_d;
    logic             skip_q, skip_d;

    always_comb begin
        row_d  = row_q;
        col_d  = col_q;
        skip_d = 1'b0;
        case (dec_i.op)
            OP_XCH: begin
                row_d = row_q ^ ROW_W'(dec_i.imm);
            end
            OP_XCH_INC: begin
                row_d  = row_q ^ ROW_W'(dec_i.imm);
                col_d  = col_q + COL_ONE;
                skip_d = (col_q == COL_MAX);
            end
            OP_XCH_DEC: begin
                row_d  = row_q ^ ROW_W'(dec_i.imm);
                col_d  = col_q - COL_ONE;
                skip_d = (col_q == '0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= '0;
            col_q  <= '0;
            skip_q <= 1'b0;
        end else begin
            row_q  <= row_d;
            col_q  <= col_d;
            skip_q <= skip_d;
        end
    end

    assign row_o  = row_q;
    assign col_o  = col_q;
    assign skip_o = skip_q;
endmodule

// File: rtl/xch_nibble_ram.sv
`timescale 1ns/1ps
module xch_nibble_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end
endmodule

// File: rtl/xch_unit.sv
`timescale 1ns/1ps
module xch_unit
    import xch_pkg::*;
#(
    parameter int ROW_W  = 2,
    parameter int COL_W  = 4,
    parameter int DATA_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [8:0]         instr,
    input  logic               acc_wr_en,
    input  logic [DATA_W-1:0]  acc_wr_data,
    output logic [DATA_W-1:0]  acc_o,
    output logic [ROW_W-1:0]   row_o,
    output logic [COL_W-1:0]   col_o,
    output logic               skip_o,
    output logic               wdt_clr_o
);
    localparam int ADDR_W = ROW_W + COL_W;

    dec_t              dec;
    logic              xch;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] ram_rd;
    logic              wdt_q;

    xch_decoder u_dec (
        .instr (instr),
        .dec_o (dec),
        .xch_o (xch)
    );

    xch_pointer #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .dec_i  (dec),
        .row_o  (row_o),
        .col_o  (col_o),
        .skip_o (skip_o)
    );

    xch_nibble_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (xch && !rst),
        .addr  ({row_o, col_o}),
        .wdata (acc_q),
        .rdata (ram_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            wdt_q <= 1'b0;
        end else begin
            wdt_q <= (dec.op == OP_WDT);
            if (xch)            acc_q <= ram_rd;
            else if (acc_wr_en) acc_q <= acc_wr_data;
        end
    end

    assign acc_o     = acc_q;
    assign wdt_clr_o = wdt_q;
endmodule

// File: rtl/xch_unit_chk.sv
`timescale 1ns/1ps
module xch_unit_chk #(
    parameter int ROW_W  = 2,
    parameter int COL_W  = 4,
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [8:0]        instr,
    input logic              acc_wr_en,
    input logic [DATA_W-1:0] acc_o,
    input logic [ROW_W-1:0]  row_o,
    input logic [COL_W-1:0]  col_o,
    input logic              skip_o,
    input logic              wdt_clr_o
);
    logic c_plain, c_inc, c_dec, c_any, c_wdt;
    assign c_plain = (instr[8:2] == 7'b0011000);
    assign c_inc   = (instr[8:2] == 7'b0011010);
    assign c_dec   = (instr[8:2] == 7'b0011011);
    assign c_any   = c_plain || c_inc || c_dec;
    assign c_wdt   = (instr == 9'h00F);

    p_plain_col_r2: assert property (@(posedge clk) disable iff (rst)
        c_plain |=> (col_o == $past(col_o)) && !skip_o);

    p_row_xor_r3: assert property (@(posedge clk) disable iff (rst)
        c_any |=> row_o == ($past(row_o) ^ ROW_W'($past(instr[1:0]))));

    p_col_inc_r4: assert property (@(posedge clk) disable iff (rst)
        c_inc |=> col_o == COL_W'($past(col_o) + 1'b1));

    p_col_dec_r5: assert property (@(posedge clk) disable iff (rst)
        c_dec |=> col_o == COL_W'($past(col_o) - 1'b1));

    p_skip_cause_r6: assert property (@(posedge clk) disable iff (rst)
        skip_o |-> ($past(c_inc) && ($past(col_o) == {COL_W{1'b1}}))
                || ($past(c_dec) && ($past(col_o) == '0)));

    p_wdt_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        c_wdt |=> wdt_clr_o && $stable(row_o) && $stable(col_o) && !skip_o);

    p_wdt_cause_r7: assert property (@(posedge clk) disable iff (rst)
        wdt_clr_o |-> $past(c_wdt));

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!c_any && !c_wdt && !acc_wr_en) |=>
            $stable(row_o) && $stable(col_o) && $stable(acc_o) && !skip_o && !wdt_clr_o);
endmodule

bind xch_unit xch_unit_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .instr     (instr),
    .acc_wr_en (acc_wr_en),
    .acc_o     (acc_o),
    .row_o     (row_o),
    .col_o     (col_o),
    .skip_o    (skip_o),
    .wdt_clr_o (wdt_clr_o)
);

// File: tb/xch_unit_test.sv
`timescale 1ns/1ps
module xch_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] instr = 9'h000;
    logic       acc_wr_en = 1'b0;
    logic [3:0] acc_wr_data = 4'h0;
    logic [3:0] acc_o;
    logic [1:0] row_o;
    logic [3:0] col_o;
    logic       skip_o;
    logic       wdt_clr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state; -1 marks an unknown nibble
    int m_mem [64];
    int m_acc, m_row, m_col, m_skip, m_wdt;

    always #10 clk = ~clk;

    xch_unit uut (
        .clk(clk), .rst(rst), .instr(instr),
        .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
        .acc_o(acc_o), .row_o(row_o), .col_o(col_o),
        .skip_o(skip_o), .wdt_clr_o(wdt_clr_o)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic step(input logic [8:0] ins, input logic wen, input logic [3:0] wd);
        int addr, na, j;
        bit plain, inc, dec;
        string acc_req, col_req;
        instr = ins; acc_wr_en = wen; acc_wr_data = wd;
        plain = ((ins & 9'h1FC) == 9'h060);
        inc   = ((ins & 9'h1FC) == 9'h068);
        dec   = ((ins & 9'h1FC) == 9'h06C);
        j = int'(ins & 9'h003);
        addr = m_row * 16 + m_col;
        m_skip = 0;
        acc_req = "R8"; col_req = "R8";
        if (plain || inc || dec) begin
            na = m_mem[addr];
            m_mem[addr] = m_acc;
            m_acc = na;
            m_row = m_row ^ j;
            acc_req = wen ? "R9" : "R2";
            col_req = "R2";
            if (inc) begin m_col = (m_col + 1) % 16; m_skip = (m_col == 0);  col_req = "R4"; end
            if (dec) begin m_col = (m_col + 15) % 16; m_skip = (m_col == 15); col_req = "R5"; end
        end else if (wen) begin
            m_acc = int'(wd);
            acc_req = "R9";
        end
        m_wdt = (ins == 9'h00F);
        @(posedge clk);
        @(negedge clk);
        if (m_acc >= 0) check(acc_req, "acc", int'(acc_o), m_acc);
        check("R3", "row", int'(row_o), m_row);
        check(col_req, "col", int'(col_o), m_col);
        check("R6", "skip", int'(skip_o), m_skip);
        check("R7", "wdt_clr", int'(wdt_clr_o), m_wdt);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        foreach (m_mem[i]) m_mem[i] = -1;
        m_acc = 0; m_row = 0; m_col = 0; m_skip = 0; m_wdt = 0;
        repeat (4) @(negedge clk);
        // R1: state after reset
        check("R1", "acc", int'(acc_o), 0);
        check("R1", "row", int'(row_o), 0);
        check("R1", "col", int'(col_o), 0);
        check("R1", "skip", int'(skip_o), 0);
        check("R1", "wdt_clr", int'(wdt_clr_o), 0);
        rst = 1'b0;

        // R5 boundary: column 0 steps down to 15 and skips
        step(9'h06C, 1'b0, 4'h0);
        check("R5", "wrap skip", int'(skip_o), 1);
        // R4 boundary: column 15 steps up to 0 and skips
        step(9'h068, 1'b0, 4'h0);
        check("R4", "wrap skip", int'(skip_o), 1);
        // R6: skip drops after a non-wrapping step
        step(9'h068, 1'b0, 4'h0);
        check("R6", "skip low", int'(skip_o), 0);
        // R7: watchdog code
        step(9'h00F, 1'b0, 4'h0);
        check("R7", "pulse", int'(wdt_clr_o), 1);
        step(9'h000, 1'b0, 4'h0);
        check("R7", "pulse ends", int'(wdt_clr_o), 0);

        // return to row 0, column 0, then fill every cell with known data
        step(9'h06C, 1'b0, 4'h0);
        step(9'h060 | 9'(m_row), 1'b0, 4'h0);
        for (int i = 0; i < 64; i++) begin
            int r, jj;
            r = i / 16;
            jj = ((i % 16) == 15) ? ((r ^ ((r + 1) % 4)) & 3) : 0;
            step(9'h000, 1'b1, 4'((i * 7 + 3) % 16));
            step(9'h068 | 9'(jj), 1'b0, 4'h0);
        end

        // R9: load port ignored during an exchange
        step(9'h000, 1'b1, 4'hA);
        step(9'h060, 1'b1, 4'h5);
        step(9'h060, 1'b1, 4'h3);
        check("R9", "acc after swap back", int'(acc_o), 10);
        // R8: unused codes in and near the exchange group
        for (int k = 0; k < 4; k++) step(9'h064 + 9'(k), 1'b0, 4'h0);
        step(9'h160, 1'b0, 4'h0);
        step(9'h16C, 1'b0, 4'h0);
        step(9'h10F, 1'b0, 4'h0);
        // R3: every immediate value on each exchange form
        for (int k = 0; k < 4; k++) begin
            step(9'h060 + 9'(k), 1'b0, 4'h0);
            step(9'h068 + 9'(k), 1'b0, 4'h0);
            step(9'h06C + 9'(k), 1'b0, 4'h0);
        end

        // mixed stream
        for (int n = 0; n < 4000; n++) begin
            int sel;
            logic [8:0] code;
            sel = $urandom_range(0, 15);
            case (sel)
                0, 1, 2:  code = 9'h060 + 9'($urandom_range(0, 3));
                3, 4, 5:  code = 9'h068 + 9'($urandom_range(0, 3));
                6, 7, 8:  code = 9'h06C + 9'($urandom_range(0, 3));
                9:        code = 9'h00F;
                10:       code = 9'h064 + 9'($urandom_range(0, 3));
                11:       code = 9'h100 | 9'($urandom_range(0, 255));
                12:       code = 9'($urandom_range(0, 511));
                default:  code = 9'h000;
            endcase
            step(code, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule